// File: doc/BRIEF.md
# Chunked Bitmap Rank Index Unit

This unit turns a bit position in a large, sparse flag vector into a dense index into a compressed table. The table holds one entry for each set bit of the vector, in the order of the bits. The vector is kept in memory as 32-bit chunks. A second memory holds, for each chunk, the number of ones in all chunks below it. For each query the unit reads the chunk that holds the position and that chunk's prefix count. It counts the ones in the chunk that lie strictly below the queried bit and adds the prefix count. It reports the sum together with the value of the queried bit.

The same unit serves a global flag vector, such as a next-hop table indexed by a 16-bit key, and a segmented vector. For a segmented vector the caller supplies a per-segment base count with the query, which is the number of table entries held by earlier segments. The base is added to the index. For a global vector the base is zero. The unit accepts one query per cycle. The chunk and prefix-count memories have a one-cycle synchronous read. The result is registered one cycle after that data arrives.

Top module: `rank_index_unit`

## Requirements
- R1: In the cycle a query is presented (`q_valid` high), `mem_rd_en` is high and `mem_rd_addr` equals the chunk number, `q_pos[POS_W-1:5]`. With no query, `mem_rd_en` is low.
- R2: `res_present` equals bit `q_pos[4:0]` of the chunk word returned for the query, with bit 0 as the least significant bit.
- R3: The in-chunk count includes only the bits strictly below the queried bit. A query at bit 0 of a chunk adds nothing from the chunk, so the first set bit of the whole vector gets index 0.
- R4: `res_index` equals `q_base + rd_offset + (number of ones in rd_chunk at bit positions below q_pos[4:0])`. The index is formed this way whether or not the queried bit is set.
- R5: A result appears with `res_valid` high exactly two cycles after its query, which is one cycle after the memory data. Back-to-back queries produce back-to-back results in order. No result appears without a query.
- R6: In a cycle with no new result, `res_index` and `res_present` keep their previous values and `res_valid` is low.
- R7: While reset is asserted and after it is released, `res_valid`, `res_present` and `res_index` are zero until the first result.
- R8: For every legal input the sum fits in `IDX_W` bits. With the default sizes, a query at position 65535 of an all-ones vector gives index 65535 without wrapping.
- R9: The top bit of a chunk (bit 31) counts all 31 bits below it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_valid | input | 1 | Query strobe |
| q_pos | input | POS_W (16) | Queried bit position in the vector |
| q_base | input | IDX_W (17) | Count of entries in earlier segments (0 for a global vector) |
| mem_rd_en | output | 1 | Read enable to the chunk and prefix-count memories |
| mem_rd_addr | output | CHUNK_AW (11) | Chunk number to read |
| rd_chunk | input | CHUNK_W (32) | Chunk word, one cycle after the read |
| rd_offset | input | IDX_W (17) | Ones in all lower chunks, one cycle after the read |
| res_valid | output | 1 | Result strobe |
| res_index | output | IDX_W (17) | Dense index of the queried position |
| res_present | output | 1 | Queried bit is set |

## Verification
The assertions check on every cycle that each query yields exactly one result two cycles later and that none appears without a query. They also check that the in-chunk count never exceeds the queried bit number and is zero at bit 0. Two more properties check that the adder never carries out for a valid result and that the outputs hold still in idle cycles. The value of the index itself can only be shown by the bench's scenarios. These use sparse and dense chunk patterns, nonzero segment bases, queries at chunk edges, the all-ones top of the vector, and back-to-back streams where the memory contents are compared against an independently computed rank.

// File: rtl/rank_pkg.sv
package rank_pkg;
  // Arithmetic helpers shared by the rank stages; chunk widths up to 64 bits.
  function automatic logic [6:0] count_ones(input logic [63:0] v);
    logic [6:0] n;
    n = '0;
    for (int i = 0; i < 64; i++) n = n + 7'(v[i]);
    return n;
  endfunction

  // Three-operand sum with a carry bit above the result width.
  function automatic logic [64:0] add3(input logic [63:0] a, input logic [63:0] b,
                                       input logic [63:0] c);
    return 65'(a) + 65'(b) + 65'(c);
  endfunction
endpackage

// File: rtl/rank_query_stage.sv
module rank_query_stage #(
  parameter int POS_W    = 16,
  parameter int SEL_W    = 5,
  parameter int IDX_W    = 17,
  localparam int CHUNK_AW = POS_W - SEL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                q_valid,
  input  logic [POS_W-1:0]    q_pos,
  input  logic [IDX_W-1:0]    q_base,
  output logic                mem_rd_en,
  output logic [CHUNK_AW-1:0] mem_rd_addr,
  output logic                s1_valid,
  output logic [SEL_W-1:0]    s1_sel,
  output logic [IDX_W-1:0]    s1_base
);
  // Chunk number goes straight to the memories; bit select and base wait for the data.
  assign mem_rd_en   = q_valid;
  assign mem_rd_addr = q_pos[POS_W-1:SEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sel   <= '0;
      s1_base  <= '0;
    end else begin
      s1_valid <= q_valid;
      if (q_valid) begin
        s1_sel  <= q_pos[SEL_W-1:0];
        s1_base <= q_base;
      end
    end
  end
endmodule

// File: rtl/rank_popcount.sv
module rank_popcount #(
  parameter int CHUNK_W = 32,
  localparam int SEL_W  = $clog2(CHUNK_W),
  localparam int CNT_W  = $clog2(CHUNK_W + 1)
) (
  input  logic [CHUNK_W-1:0] chunk,
  input  logic [SEL_W-1:0]   sel,
  output logic [CNT_W-1:0]   cnt,
  output logic               bit_set
);
  logic [CHUNK_W-1:0] below;

  // Keep only the chunk bits strictly under the selected bit.
  for (genvar i = 0; i < CHUNK_W; i++) begin : g_mask
    assign below[i] = chunk[i] & (i < int'(sel));
  end

  assign cnt     = CNT_W'(rank_pkg::count_ones(64'(below)));
  assign bit_set = chunk[sel];
endmodule

// File: rtl/rank_sum_stage.sv
module rank_sum_stage #(
  parameter int IDX_W = 17,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic [IDX_W-1:0] base,
  input  logic [IDX_W-1:0] offset,
  input  logic [CNT_W-1:0] cnt,
  input  logic             bit_set,
  output logic             res_valid,
  output logic [IDX_W-1:0] res_index,
  output logic             res_present
);
  logic [64:0]      full_sum;
  logic [IDX_W-1:0] sum;
  logic             sum_carry;

  assign full_sum  = rank_pkg::add3(64'(base), 64'(offset), 64'(cnt));
  assign sum       = full_sum[IDX_W-1:0];
  assign sum_carry = |full_sum[64:IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_index   <= '0;
      res_present <= 1'b0;
    end else begin
      res_valid <= s1_valid;
      if (s1_valid) begin
        res_index   <= sum;
        res_present <= bit_set;
      end
    end
  end

  // R8: legal inputs never wrap the index.
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> !sum_carry);
endmodule

// File: rtl/rank_index_unit.sv
module rank_index_unit #(
  parameter int CHUNK_W    = 32,
  parameter int NUM_CHUNKS = 2048,
  localparam int SEL_W     = $clog2(CHUNK_W),
  localparam int CHUNK_AW  = $clog2(NUM_CHUNKS),
  localparam int POS_W     = CHUNK_AW + SEL_W,
  localparam int CNT_W     = $clog2(CHUNK_W + 1),
  localparam int IDX_W     = $clog2(NUM_CHUNKS * CHUNK_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                q_valid,
  input  logic [POS_W-1:0]    q_pos,
  input  logic [IDX_W-1:0]    q_base,
  output logic                mem_rd_en,
  output logic [CHUNK_AW-1:0] mem_rd_addr,
  input  logic [CHUNK_W-1:0]  rd_chunk,
  input  logic [IDX_W-1:0]    rd_offset,
  output logic                res_valid,
  output logic [IDX_W-1:0]    res_index,
  output logic                res_present
);
  logic             s1_valid;
  logic [SEL_W-1:0] s1_sel;
  logic [IDX_W-1:0] s1_base;
  logic [CNT_W-1:0] pc_cnt;
  logic             pc_bit;

  rank_query_stage #(.POS_W(POS_W), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_query (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_pos(q_pos), .q_base(q_base),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .s1_valid(s1_valid), .s1_sel(s1_sel), .s1_base(s1_base));

  rank_popcount #(.CHUNK_W(CHUNK_W)) u_pop (
    .chunk(rd_chunk), .sel(s1_sel), .cnt(pc_cnt), .bit_set(pc_bit));

  rank_sum_stage #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .base(s1_base),
    .offset(rd_offset), .cnt(pc_cnt), .bit_set(pc_bit),
    .res_valid(res_valid), .res_index(res_index), .res_present(res_present));

  // R5: each query gives one result two cycles later, and nothing else does.
  a_r5_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> ##2 res_valid);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |-> ##2 !res_valid);

  // R3: the in-chunk count covers only bits under the selected bit.
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (CNT_W'(pc_cnt) <= CNT_W'(s1_sel)));
  a_r3_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_sel == '0) |-> (pc_cnt == '0));

  // R6: idle cycles leave the outputs untouched.
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> (!res_valid && $stable(res_index) && $stable(res_present)));
endmodule

// File: tb/rank_index_unit_tb.sv
module rank_index_unit_tb;
  localparam int NCH = 2048;
  localparam int IW  = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          q_valid = 1'b0;
  logic [15:0]   q_pos = '0;
  logic [IW-1:0] q_base = '0;
  logic          mem_rd_en;
  logic [10:0]   mem_rd_addr;
  logic [31:0]   rd_chunk;
  logic [IW-1:0] rd_offset;
  logic          res_valid;
  logic [IW-1:0] res_index;
  logic          res_present;

  logic [31:0]   mem_word [NCH];
  logic [IW-1:0] mem_off  [NCH];

  int checks = 0;
  int errors = 0;
  logic [IW:0] exp_q [$];   // {present, index}
  string       tag_q [$];

  always #5 clk = ~clk;

  rank_index_unit u_dut (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_pos(q_pos), .q_base(q_base),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .rd_chunk(rd_chunk), .rd_offset(rd_offset),
    .res_valid(res_valid), .res_index(res_index), .res_present(res_present));

  // Synchronous one-cycle memory model.
  always_ff @(posedge clk) begin
    if (mem_rd_en) begin
      rd_chunk  <= mem_word[mem_rd_addr];
      rd_offset <= mem_off[mem_rd_addr];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill(input int mode, input logic [31:0] seed);
    logic [31:0] s;
    int run;
    s = seed;
    run = 0;
    for (int c = 0; c < NCH; c++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      case (mode)
        0: mem_word[c] = s;
        1: mem_word[c] = s & (s >> 7) & (s << 3);
        default: mem_word[c] = '1;
      endcase
    end
    if (mode != 2) begin
      mem_word[0] = 32'h0000_0001;
      mem_word[5] = 32'h8000_0000;
      mem_word[6] = 32'hFFFF_FFFF;
      mem_word[7] = 32'h0000_0000;
    end
    for (int c = 0; c < NCH; c++) begin
      mem_off[c] = IW'(run);
      run += $countones(mem_word[c]);
    end
  endtask

  // Driver: present one query on a falling edge and record its expected result.
  task automatic send(input logic [15:0] pos, input logic [IW-1:0] base, input string req);
    int c, b, idx;
    c = int'(pos[15:5]);
    b = int'(pos[4:0]);
    idx = int'(base) + int'(mem_off[c]);
    for (int k = b - 1; k >= 0; k--) idx += int'(mem_word[c][k]);
    exp_q.push_back({mem_word[c][b], IW'(idx)});
    tag_q.push_back(req);
    @(negedge clk);
    q_valid = 1'b1;
    q_pos   = pos;
    q_base  = base;
    #1;
    check("R1 rd_en", 32'(mem_rd_en), 32'd1);
    check("R1 rd_addr", 32'(mem_rd_addr), 32'(c));
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    q_valid = 1'b0;
    #1;
    check("R1 rd_en idle", 32'(mem_rd_en), 32'd0);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare each result against the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check("R5 spurious result", 32'd1, 32'd0);
      end else begin
        logic [IW:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " index"}, 32'(res_index), 32'(e[IW-1:0]));
        check({t, " present"}, 32'(res_present), 32'(e[IW]));
      end
    end
  end

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    fill(0, 32'h1234_5677);
    repeat (3) @(negedge clk);
    check("R7 valid in reset", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 valid", 32'(res_valid), 32'd0);
    check("R7 index", 32'(res_index), 32'd0);
    check("R7 present", 32'(res_present), 32'd0);

    // Dense words, isolated queries and edge bits.
    send(16'd0, '0, "R3 first bit");           idle(3);
    send(16'd1, '0, "R3 above first");          idle(3);
    send(16'd191, '0, "R9 chunk5 top bit");     idle(3);
    send(16'd192, '0, "R3 chunk6 bit0");        idle(3);
    send(16'd223, '0, "R9 all-ones top");       idle(3);
    send(16'd230, '0, "R2 empty chunk");        idle(3);
    // R6: outputs hold through idle cycles.
    begin
      logic [IW-1:0] hi; logic hp;
      hi = res_index; hp = res_present;
      repeat (4) @(negedge clk);
      check("R6 index hold", 32'(res_index), 32'(hi));
      check("R6 present hold", 32'(res_present), 32'(hp));
      check("R6 valid low", 32'(res_valid), 32'd0);
    end

    // R4/R5: back-to-back stream with segment bases.
    for (int i = 0; i < 200; i++)
      send(16'((i * 3307 + 11) & 16'hFFFF), IW'((i % 4) * 250), "R5 R4 stream");
    idle(4);

    // Sparse vector.
    fill(1, 32'h0BAD_F00D);
    for (int i = 0; i < 150; i++)
      send(16'((i * 439 + 5) & 16'hFFFF), IW'(i % 3 == 0 ? 77 : 0), "R2 R4 sparse");
    idle(4);

    // All-ones vector: largest legal index.
    fill(2, 32'h1);
    send(16'hFFFF, '0, "R8 max index");
    send(16'hFFE0, '0, "R8 last chunk bit0");
    send(16'd32, '0, "R3 chunk1 bit0");
    idle(4);

    check("R5 all results seen", 32'(exp_q.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule